// File: doc/BRIEF.md
# Buffered Input Capture Group

This block stores timer snapshots for a group of input capture channels. Each channel has a capture register and a holding register behind it. When a qualified edge strobe arrives, the channel stores the current value of a free-running timer. The holding register adds a second stage. In queue mode, each new capture pushes the older one back into the holding register. In latch mode, a shared latch event copies every capture register into its holding register in the same clock cycle.

The latch event is either a software latch strobe or a strobe from the modulus counter that marks that it has reached zero. Each channel has a sticky flag. In the normal flag mode the flag is set on every capture. In the alternative flag mode, queue mode sets the flag only when the holding register is loaded, so software is interrupted once for each pair of captures. Reading a capture register, signalled by a read strobe, marks it empty. The next queued edge into an empty capture register then loads only the capture register.

Top module: `buffered_ic`

## Requirements
- R1: Reset (synchronous, active high) clears every capture register, every holding register and every flag to zero, and marks every capture register empty.
- R2: On a channel's edge strobe, its capture register takes the timer value at the next clock edge, in every mode. A capture register becomes full on any edge and empty after its read strobe, unless an edge arrives in the same cycle.
- R3: In queue mode (buf_en=1, latch_sel=0), an edge on a channel whose capture register is full copies the old capture value into the holding register in the same cycle that the new timer value is captured.
- R4: In queue mode, an edge on a channel whose capture register is empty loads only the capture register and leaves the holding register unchanged.
- R5: In latch mode (buf_en=1, latch_sel=1), a pulse on sw_latch or on mc_zero copies every channel's capture register into its holding register at the next clock edge.
- R6: Outside latch mode, sw_latch and mc_zero leave every holding register unchanged. With buf_en=0 the holding registers never change.
- R7: With flag_on_hold=0, an edge on a channel sets that channel's flag, in any mode.
- R8: With flag_on_hold=1 in queue mode, a channel's flag is set only by an edge that moves a value into its holding register. An edge into an empty capture register sets no flag.
- R9: With flag_on_hold=1 outside queue mode, flags are set on every edge, as with flag_on_hold=0.
- R10: Flags stay set until a 1 on the channel's flag_clr bit clears them. A set and a clear in the same cycle leave the flag set.
- R11: Channels are independent. An edge, read or clear on one channel does not change another channel's capture register, holding register or flag.
- R12: In latch mode, an edge arriving in the same cycle as a latch event puts the previous capture value in the holding register and the new timer value in the capture register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_val | input | TW | Free-running timer value |
| cap_edge | input | NCH | Qualified capture edge strobe, one bit per channel |
| buf_en | input | 1 | Enables the holding registers |
| latch_sel | input | 1 | 1 selects latch mode, 0 selects queue mode (when buf_en=1) |
| flag_on_hold | input | 1 | Flag mode: set flags on holding-register loads in queue mode |
| sw_latch | input | 1 | Software latch command strobe |
| mc_zero | input | 1 | Modulus counter reached zero, or zero was written to it |
| cap_rd | input | NCH | Capture register read strobe, marks it empty |
| flag_clr | input | NCH | Write-one-to-clear of the flags |
| cap_val | output | NCH*TW | Capture registers, channel i at bits [i*TW +: TW] |
| hold_val | output | NCH*TW | Holding registers, channel i at bits [i*TW +: TW] |
| flag | output | NCH | Sticky channel flags |

## Verification
The bench targets the empty-capture rule of queue mode. It checks that the first edge after a read does not shift a value into the holding register, while the following edge does. A design that shifted every time would overwrite the holding register with a value software had already consumed. With flag_on_hold set, that same design would also raise a flag too early. The bench also fires an edge in the same cycle as a latch event. A design with the update order wrong would place the new timer value in the holding register. It pulses latch strobes in queue and direct modes, which a design that ignored the mode would act on. It issues a flag set and clear in the same cycle, which a design where the clear wins would lose.

// File: rtl/icb_pkg.sv
package icb_pkg;
  typedef enum logic [1:0] {
    ICB_DIRECT = 2'd0,
    ICB_QUEUE  = 2'd1,
    ICB_LATCH  = 2'd2
  } icb_mode_e;
endpackage

// File: rtl/icb_mode_dec.sv
module icb_mode_dec
  import icb_pkg::*;
(
  input  logic      buf_en,
  input  logic      latch_sel,
  input  logic      flag_on_hold,
  output icb_mode_e mode,
  output logic      flag_on_xfer
);
  always_comb begin
    if (!buf_en)        mode = ICB_DIRECT;
    else if (latch_sel) mode = ICB_LATCH;
    else                mode = ICB_QUEUE;
  end

  // the alternative flag mode only takes effect in queue mode
  assign flag_on_xfer = flag_on_hold && (mode == ICB_QUEUE);
endmodule

// File: rtl/icb_channel.sv
module icb_channel
  import icb_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  icb_mode_e     mode,
  input  logic          flag_on_xfer,
  input  logic          latch_evt,
  input  logic [TW-1:0] timer,
  input  logic          edge_stb,
  input  logic          cap_rd,
  input  logic          flag_clr,
  output logic [TW-1:0] cap_q,
  output logic [TW-1:0] hold_q,
  output logic          flag_q
);
  logic cap_full;
  logic q_shift;
  logic l_copy;
  logic flag_set;

  assign q_shift  = (mode == ICB_QUEUE) && edge_stb && cap_full;
  assign l_copy   = (mode == ICB_LATCH) && latch_evt;
  assign flag_set = flag_on_xfer ? q_shift : edge_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q    <= '0;
      hold_q   <= '0;
      cap_full <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (edge_stb) cap_q <= timer;
      if (q_shift || l_copy) hold_q <= cap_q;
      if (edge_stb)    cap_full <= 1'b1;
      else if (cap_rd) cap_full <= 1'b0;
      flag_q <= (flag_q && !flag_clr) || flag_set;
    end
  end

  AST_EDGE_LOADS_CAP: assert property (@(posedge clk) disable iff (rst)
    edge_stb |=> cap_q == $past(timer)); // R2
  AST_QUEUE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (mode == ICB_QUEUE && edge_stb && cap_full) |=> hold_q == $past(cap_q)); // R3
  AST_EMPTY_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (mode == ICB_QUEUE && edge_stb && !cap_full) |=> $stable(hold_q)); // R4
  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
    (mode == ICB_LATCH && latch_evt) |=> hold_q == $past(cap_q)); // R5
  AST_DIRECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mode == ICB_DIRECT) |=> $stable(hold_q)); // R6
  AST_EDGE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!flag_on_xfer && edge_stb) |=> flag_q); // R7
  AST_XFER_ONLY_FLAG: assert property (@(posedge clk) disable iff (rst)
    (flag_on_xfer && !flag_q && !(edge_stb && cap_full)) |=> !flag_q); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q); // R10
endmodule

// File: rtl/buffered_ic.sv
module buffered_ic
  import icb_pkg::*;
#(
  parameter int NCH = 4,
  parameter int TW  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TW-1:0]     timer_val,
  input  logic [NCH-1:0]    cap_edge,
  input  logic              buf_en,
  input  logic              latch_sel,
  input  logic              flag_on_hold,
  input  logic              sw_latch,
  input  logic              mc_zero,
  input  logic [NCH-1:0]    cap_rd,
  input  logic [NCH-1:0]    flag_clr,
  output logic [NCH*TW-1:0] cap_val,
  output logic [NCH*TW-1:0] hold_val,
  output logic [NCH-1:0]    flag
);
  localparam int BUSW = NCH * TW;

  icb_mode_e mode;
  logic      flag_on_xfer;
  logic      latch_evt;

  assign latch_evt = sw_latch || mc_zero;

  icb_mode_dec u_mode (
    .buf_en       (buf_en),
    .latch_sel    (latch_sel),
    .flag_on_hold (flag_on_hold),
    .mode         (mode),
    .flag_on_xfer (flag_on_xfer)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    icb_channel #(.TW(TW)) u_ch (
      .clk          (clk),
      .rst          (rst),
      .mode         (mode),
      .flag_on_xfer (flag_on_xfer),
      .latch_evt    (latch_evt),
      .timer        (timer_val),
      .edge_stb     (cap_edge[i]),
      .cap_rd       (cap_rd[i]),
      .flag_clr     (flag_clr[i]),
      .cap_q        (cap_val[i*TW +: TW]),
      .hold_q       (hold_val[i*TW +: TW]),
      .flag_q       (flag[i])
    );
  end

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cap_val == {BUSW{1'b0}}) && (hold_val == {BUSW{1'b0}}) && (flag == '0)); // R1
endmodule

// File: tb/buffered_ic_tb_top.sv
`timescale 1ns/1ps
module buffered_ic_tb_top;
  localparam int NCH = 4;
  localparam int TW  = 16;
  localparam int NV  = 12;

  typedef struct packed {
    logic        be, ls, foh, sw, mz;
    logic [3:0]  edg, rd, clr;
    logic [15:0] tmr, ecap, ehold;
    logic [3:0]  eflag;
    logic [7:0]  req;
  } vec_t;

  // expected values are for channel 0 capture/hold and all flags
  localparam vec_t VEC [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 4'b0001,4'b0000,4'b0000, 16'h0100,16'h0100,16'h0000, 4'b0001, 8'd4 }, // R4 empty first edge
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 4'b0001,4'b0000,4'b0001, 16'h0200,16'h0200,16'h0100, 4'b0001, 8'd3 }, // R3 shift, R10 set wins
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 4'b0000,4'b0000,4'b0001, 16'h0300,16'h0200,16'h0100, 4'b0000, 8'd10}, // R10 clear
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 4'b0000,4'b0001,4'b0000, 16'h0350,16'h0200,16'h0100, 4'b0000, 8'd2 }, // R2 read empties
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 4'b0001,4'b0000,4'b0000, 16'h0400,16'h0400,16'h0100, 4'b0000, 8'd8 }, // R8 no flag on empty edge
    '{1'b1,1'b0,1'b1,1'b0,1'b0, 4'b0001,4'b0000,4'b0000, 16'h0500,16'h0500,16'h0400, 4'b0001, 8'd8 }, // R8 flag on shift
    '{1'b1,1'b1,1'b1,1'b0,1'b0, 4'b0010,4'b0000,4'b0000, 16'h0600,16'h0500,16'h0400, 4'b0011, 8'd9 }, // R9 latch mode edge flag
    '{1'b1,1'b1,1'b1,1'b0,1'b1, 4'b0000,4'b0000,4'b0000, 16'h0650,16'h0500,16'h0500, 4'b0011, 8'd5 }, // R5 mc_zero copy
    '{1'b1,1'b1,1'b0,1'b1,1'b0, 4'b0001,4'b0000,4'b1111, 16'h0700,16'h0700,16'h0500, 4'b0001, 8'd12}, // R12 edge with sw latch
    '{1'b0,1'b1,1'b0,1'b1,1'b0, 4'b0001,4'b0000,4'b0000, 16'h0800,16'h0800,16'h0500, 4'b0001, 8'd6 }, // R6 direct ignores latch
    '{1'b1,1'b0,1'b0,1'b0,1'b1, 4'b0000,4'b0000,4'b0000, 16'h0850,16'h0800,16'h0500, 4'b0001, 8'd6 }, // R6 queue ignores mc_zero
    '{1'b1,1'b0,1'b0,1'b0,1'b0, 4'b0001,4'b0000,4'b0000, 16'h0900,16'h0900,16'h0800, 4'b0001, 8'd7 }  // R7 flag on edge, R3
  };

  logic              clk = 1'b0;
  logic              rst;
  logic [TW-1:0]     timer_val;
  logic [NCH-1:0]    cap_edge, cap_rd, flag_clr;
  logic              buf_en, latch_sel, flag_on_hold, sw_latch, mc_zero;
  logic [NCH*TW-1:0] cap_val, hold_val;
  logic [NCH-1:0]    flag;
  int tests = 0;
  int fails = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  buffered_ic #(.NCH(NCH), .TW(TW)) dut_i (
    .clk(clk), .rst(rst), .timer_val(timer_val), .cap_edge(cap_edge),
    .buf_en(buf_en), .latch_sel(latch_sel), .flag_on_hold(flag_on_hold),
    .sw_latch(sw_latch), .mc_zero(mc_zero), .cap_rd(cap_rd),
    .flag_clr(flag_clr), .cap_val(cap_val), .hold_val(hold_val), .flag(flag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cap_edge = '0; cap_rd = '0; flag_clr = '0; sw_latch = 1'b0; mc_zero = 1'b0;
  endtask

  initial begin
    rst = 1'b1; timer_val = '0; buf_en = 1'b0; latch_sel = 1'b0; flag_on_hold = 1'b0;
    idle();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 cap", 64'(cap_val), 64'h0);
    chk("R1 hold", 64'(hold_val), 64'h0);
    chk("R1 flag", 64'(flag), 64'h0);

    for (int v = 0; v < NV; v++) begin
      buf_en = VEC[v].be; latch_sel = VEC[v].ls; flag_on_hold = VEC[v].foh;
      sw_latch = VEC[v].sw; mc_zero = VEC[v].mz; cap_edge = VEC[v].edg;
      cap_rd = VEC[v].rd; flag_clr = VEC[v].clr; timer_val = VEC[v].tmr;
      @(negedge clk);
      idle();
      chk($sformatf("R%0d vec%0d cap0", VEC[v].req, v), 64'(cap_val[TW-1:0]), 64'(VEC[v].ecap));
      chk($sformatf("R%0d vec%0d hold0", VEC[v].req, v), 64'(hold_val[TW-1:0]), 64'(VEC[v].ehold));
      chk($sformatf("R%0d vec%0d flag", VEC[v].req, v), 64'(flag), 64'(VEC[v].eflag));
    end

    // R11: channel 3 alone in queue mode, with a set/clear on every flag
    buf_en = 1'b1; latch_sel = 1'b0; flag_on_hold = 1'b0;
    cap_edge = 4'b1000; flag_clr = 4'b1111; timer_val = 16'h0A00;
    @(negedge clk);
    idle();
    chk("R11 cap0 untouched", 64'(cap_val[TW-1:0]), 64'h0900);
    chk("R11 cap3 loaded", 64'(cap_val[3*TW +: TW]), 64'h0A00);
    chk("R4 hold3 empty-edge", 64'(hold_val[3*TW +: TW]), 64'h0);
    chk("R10 set wins ch3", 64'(flag), 64'b1000);

    // R7: direct mode edge on all channels
    buf_en = 1'b0; cap_edge = 4'b1111; timer_val = 16'h0B00;
    @(negedge clk);
    idle();
    chk("R7 all flags", 64'(flag), 64'b1111);
    chk("R2 all caps", 64'(cap_val), {16'h0B00, 16'h0B00, 16'h0B00, 16'h0B00});
    chk("R6 hold0 direct", 64'(hold_val[TW-1:0]), 64'h0800);

    // R1: reset in mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid cap", 64'(cap_val), 64'h0);
    chk("R1 mid hold", 64'(hold_val), 64'h0);
    chk("R1 mid flag", 64'(flag), 64'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule